// File: doc/BRIEF.md
# Memory Initialization Sequencer

This block prepares a memory test command generator for a test run. After reset it captures the test region, a data pattern selector and a burst-size choice. It then programs the generator to write the whole region in address order with a fixed write command and a fixed burst. Each new configuration is made active by a single-cycle load strobe.

During the fill the block watches the command stream that the generator issues. When an accepted write covers the last address of the region, the block reprograms the address, instruction and burst-length modes to pseudo-random traffic. It strobes the load again and raises a sticky completion flag. The generator and the memory controller sit outside this block. The sequencer only drives their configuration inputs and observes their commands.

Top module: `meminit_seq`

## Requirements
- R1: While rst_n is low, every configuration output is zero, gen_mode_load is low and init_done is low.
- R2: On the first clock after rst_n goes high, the outputs take the fill configuration: gen_data_mode equals the pattern code (4'b0010 meaning address-as-data), gen_addr_mode = 2'b11 (sequential), gen_instr_mode = 4'b0001 (fixed instruction), gen_fixed_instr = 3'b000 (write), gen_bl_mode = 2'b01 (fixed burst), and gen_fixed_bl = 16 when cfg_long_burst is 0 or 32 when it is 1.
- R3: cfg_start_addr, cfg_end_addr, cfg_pattern and cfg_long_burst are sampled only on that first clock after reset. They appear on gen_start_addr and gen_end_addr. Later changes to these inputs have no effect until the next reset.
- R4: gen_mode_load is high for exactly one cycle, one clock after a new configuration appears. The configuration outputs hold their values in the cycle before the strobe, during it, and in the cycle after it.
- R5: The fill phase ends on a clock where cmd_valid, cmd_ready and cmd_is_write are all 1 and cmd_addr + cmd_len is greater than or equal to the captured end address. The sum is formed one bit wider than the address, so it cannot wrap.
- R6: The fill phase does not end on any of these: read commands (cmd_is_write = 0), commands without cmd_ready, writes whose sum is below the end address, and commands seen before the fill load strobe has finished.
- R7: On the clock after the completing write, gen_addr_mode becomes 2'b01, gen_instr_mode becomes 4'b0010 and gen_bl_mode becomes 2'b10 (all pseudo-random). Data mode, fixed fields and boundaries stay unchanged, and gen_mode_load pulses one clock later.
- R8: init_done rises on the clock after the traffic load strobe. It then stays high, and further commands change no output, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_addr | input | AW | Lower boundary of the test region |
| cfg_end_addr | input | AW | Upper boundary of the test region |
| cfg_pattern | input | 4 | Data pattern code for the fill |
| cfg_long_burst | input | 1 | 0 selects burst 16, 1 selects burst 32 |
| cmd_valid | input | 1 | Generator presents a command |
| cmd_ready | input | 1 | Memory side accepts the command |
| cmd_is_write | input | 1 | Presented command is a write |
| cmd_addr | input | AW | Start address of the presented command |
| cmd_len | input | 6 | Burst size of the command in address units |
| gen_data_mode | output | 4 | Data pattern mode for the generator |
| gen_addr_mode | output | 2 | Address mode for the generator |
| gen_instr_mode | output | 4 | Instruction mode for the generator |
| gen_bl_mode | output | 2 | Burst-length mode for the generator |
| gen_fixed_instr | output | 3 | Fixed instruction code |
| gen_fixed_bl | output | 6 | Fixed burst length |
| gen_start_addr | output | AW | Lower boundary driven to the generator |
| gen_end_addr | output | AW | Upper boundary driven to the generator |
| gen_mode_load | output | 1 | One-cycle strobe that activates the configuration |
| init_done | output | 1 | Fill finished and random traffic running |

## Verification
The hardest case to reach is a fill-ending write whose address plus burst runs past the top of the address space. A narrow sum would wrap and the fill would never finish. The stimulus places the end boundary near the top of the address range and then issues a long burst that overshoots it. Near-miss commands are also presented right before the real completion: a read that would reach the end, an unaccepted write, and a write one unit short. Each must leave the fill running.

// File: rtl/meminit_pkg.sv
package meminit_pkg;

    localparam int BL_W = 6;

    typedef enum logic [2:0] {
        ST_RESET         = 3'd0,
        ST_SETUP_FILL    = 3'd1,
        ST_LOAD_FILL     = 3'd2,
        ST_FILLING       = 3'd3,
        ST_SETUP_TRAFFIC = 3'd4,
        ST_LOAD_TRAFFIC  = 3'd5,
        ST_RUNNING       = 3'd6
    } seq_state_e;

    localparam logic [1:0] ADDR_MODE_SEQ    = 2'b11;
    localparam logic [1:0] ADDR_MODE_PRBS   = 2'b01;
    localparam logic [1:0] BL_MODE_FIXED    = 2'b01;
    localparam logic [1:0] BL_MODE_PRBS     = 2'b10;
    localparam logic [3:0] INSTR_MODE_FIXED = 4'b0001;
    localparam logic [3:0] INSTR_MODE_PRBS  = 4'b0010;
    localparam logic [2:0] INSTR_CODE_WR    = 3'b000;

    typedef struct packed {
        logic [3:0]      data_mode;
        logic [1:0]      addr_mode;
        logic [3:0]      instr_mode;
        logic [1:0]      bl_mode;
        logic [2:0]      fixed_instr;
        logic [BL_W-1:0] fixed_bl;
    } gen_cfg_t;

endpackage

// File: rtl/meminit_cfg_build.sv
module meminit_cfg_build
    import meminit_pkg::*;
#(
    parameter bit TRAFFIC  = 1'b0,
    parameter int BL_SHORT = 16,
    parameter int BL_LONG  = 32
) (
    input  logic [3:0] pattern,
    input  logic       long_burst,
    output gen_cfg_t   cfg
);

    localparam logic [BL_W-1:0] BL_SHORT_V = BL_W'(BL_SHORT);
    localparam logic [BL_W-1:0] BL_LONG_V  = BL_W'(BL_LONG);

    logic [1:0] addr_mode_w;
    logic [3:0] instr_mode_w;
    logic [1:0] bl_mode_w;

    // The phase is fixed at elaboration; each instance builds one variant.
    generate
        if (TRAFFIC) begin : g_traffic
            assign addr_mode_w  = ADDR_MODE_PRBS;
            assign instr_mode_w = INSTR_MODE_PRBS;
            assign bl_mode_w    = BL_MODE_PRBS;
        end else begin : g_fill
            assign addr_mode_w  = ADDR_MODE_SEQ;
            assign instr_mode_w = INSTR_MODE_FIXED;
            assign bl_mode_w    = BL_MODE_FIXED;
        end
    endgenerate

    always_comb begin
        cfg             = '0;
        cfg.data_mode   = pattern;
        cfg.addr_mode   = addr_mode_w;
        cfg.instr_mode  = instr_mode_w;
        cfg.bl_mode     = bl_mode_w;
        cfg.fixed_instr = INSTR_CODE_WR;
        cfg.fixed_bl    = long_burst ? BL_LONG_V : BL_SHORT_V;
    end

endmodule

// File: rtl/meminit_fill_detect.sv
module meminit_fill_detect
    import meminit_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          watch,
    input  logic          cmd_valid,
    input  logic          cmd_ready,
    input  logic          cmd_is_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [BL_W-1:0] cmd_len,
    input  logic [AW-1:0] end_addr,
    output logic          fill_hit
);

    localparam int SW = AW + 1;

    logic [SW-1:0] reach_w;
    logic          accepted_wr;

    always_comb begin
        reach_w     = {1'b0, cmd_addr} + SW'(cmd_len);
        accepted_wr = cmd_valid & cmd_ready & cmd_is_write;
        fill_hit    = watch & accepted_wr & (reach_w >= {1'b0, end_addr});
    end

endmodule

// File: rtl/meminit_ctrl.sv
module meminit_ctrl
    import meminit_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] start_in,
    input  logic [AW-1:0] end_in,
    input  logic [3:0]    pattern_in,
    input  logic          long_in,
    input  gen_cfg_t      fill_cfg,
    input  gen_cfg_t      traffic_cfg,
    input  logic          fill_hit,
    output logic [3:0]    pattern_q_o,
    output logic          long_q_o,
    output logic          watching,
    output gen_cfg_t      cfg_o,
    output logic [AW-1:0] start_o,
    output logic [AW-1:0] end_o,
    output logic          load_o,
    output logic          done_o
);

    typedef struct packed {
        seq_state_e    st;
        gen_cfg_t      cfg;
        logic [AW-1:0] start_a;
        logic [AW-1:0] end_a;
        logic [3:0]    pattern;
        logic          long_b;
        logic          load;
        logic          done;
    } ctrl_reg_t;

    ctrl_reg_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.load = 1'b0;
        unique case (cur_q.st)
            ST_RESET: begin
                nxt_d.st      = ST_SETUP_FILL;
                nxt_d.start_a = start_in;
                nxt_d.end_a   = end_in;
                nxt_d.pattern = pattern_in;
                nxt_d.long_b  = long_in;
                nxt_d.cfg     = fill_cfg;
            end
            ST_SETUP_FILL: begin
                nxt_d.st   = ST_LOAD_FILL;
                nxt_d.load = 1'b1;
            end
            ST_LOAD_FILL: begin
                nxt_d.st = ST_FILLING;
            end
            ST_FILLING: begin
                if (fill_hit) begin
                    nxt_d.st  = ST_SETUP_TRAFFIC;
                    nxt_d.cfg = traffic_cfg;
                end
            end
            ST_SETUP_TRAFFIC: begin
                nxt_d.st   = ST_LOAD_TRAFFIC;
                nxt_d.load = 1'b1;
            end
            ST_LOAD_TRAFFIC: begin
                nxt_d.st   = ST_RUNNING;
                nxt_d.done = 1'b1;
            end
            ST_RUNNING: begin
                nxt_d.st = ST_RUNNING;
            end
            default: begin
                nxt_d.st = ST_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pattern_q_o = cur_q.pattern;
    assign long_q_o    = cur_q.long_b;
    assign watching    = (cur_q.st == ST_FILLING);
    assign cfg_o       = cur_q.cfg;
    assign start_o     = cur_q.start_a;
    assign end_o       = cur_q.end_a;
    assign load_o      = cur_q.load;
    assign done_o      = cur_q.done;

endmodule

// File: rtl/meminit_seq.sv
module meminit_seq
    import meminit_pkg::*;
#(
    parameter int AW       = 16,
    parameter int BL_SHORT = 16,
    parameter int BL_LONG  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   cfg_start_addr,
    input  logic [AW-1:0]   cfg_end_addr,
    input  logic [3:0]      cfg_pattern,
    input  logic            cfg_long_burst,
    input  logic            cmd_valid,
    input  logic            cmd_ready,
    input  logic            cmd_is_write,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [BL_W-1:0] cmd_len,
    output logic [3:0]      gen_data_mode,
    output logic [1:0]      gen_addr_mode,
    output logic [3:0]      gen_instr_mode,
    output logic [1:0]      gen_bl_mode,
    output logic [2:0]      gen_fixed_instr,
    output logic [BL_W-1:0] gen_fixed_bl,
    output logic [AW-1:0]   gen_start_addr,
    output logic [AW-1:0]   gen_end_addr,
    output logic            gen_mode_load,
    output logic            init_done
);

    gen_cfg_t   fill_cfg_w, traffic_cfg_w, cfg_w;
    logic [3:0] pattern_q_w;
    logic       long_q_w;
    logic       watch_w;
    logic       hit_w;

    meminit_cfg_build #(.TRAFFIC(1'b0), .BL_SHORT(BL_SHORT), .BL_LONG(BL_LONG)) fill_build_i (
        .pattern    (cfg_pattern),
        .long_burst (cfg_long_burst),
        .cfg        (fill_cfg_w)
    );

    meminit_cfg_build #(.TRAFFIC(1'b1), .BL_SHORT(BL_SHORT), .BL_LONG(BL_LONG)) traffic_build_i (
        .pattern    (pattern_q_w),
        .long_burst (long_q_w),
        .cfg        (traffic_cfg_w)
    );

    meminit_fill_detect #(.AW(AW)) detect_i (
        .watch        (watch_w),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_is_write (cmd_is_write),
        .cmd_addr     (cmd_addr),
        .cmd_len      (cmd_len),
        .end_addr     (gen_end_addr),
        .fill_hit     (hit_w)
    );

    meminit_ctrl #(.AW(AW)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_in    (cfg_start_addr),
        .end_in      (cfg_end_addr),
        .pattern_in  (cfg_pattern),
        .long_in     (cfg_long_burst),
        .fill_cfg    (fill_cfg_w),
        .traffic_cfg (traffic_cfg_w),
        .fill_hit    (hit_w),
        .pattern_q_o (pattern_q_w),
        .long_q_o    (long_q_w),
        .watching    (watch_w),
        .cfg_o       (cfg_w),
        .start_o     (gen_start_addr),
        .end_o       (gen_end_addr),
        .load_o      (gen_mode_load),
        .done_o      (init_done)
    );

    assign gen_data_mode   = cfg_w.data_mode;
    assign gen_addr_mode   = cfg_w.addr_mode;
    assign gen_instr_mode  = cfg_w.instr_mode;
    assign gen_bl_mode     = cfg_w.bl_mode;
    assign gen_fixed_instr = cfg_w.fixed_instr;
    assign gen_fixed_bl    = cfg_w.fixed_bl;

endmodule

// File: rtl/meminit_seq_chk.sv
module meminit_seq_chk
    import meminit_pkg::*;
#(
    parameter int AW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      gen_data_mode,
    input logic [1:0]      gen_addr_mode,
    input logic [3:0]      gen_instr_mode,
    input logic [1:0]      gen_bl_mode,
    input logic [2:0]      gen_fixed_instr,
    input logic [BL_W-1:0] gen_fixed_bl,
    input logic [AW-1:0]   gen_start_addr,
    input logic [AW-1:0]   gen_end_addr,
    input logic            gen_mode_load,
    input logic            init_done
);

    logic [20:0] cfg_bus;
    assign cfg_bus = {gen_data_mode, gen_addr_mode, gen_instr_mode, gen_bl_mode,
                      gen_fixed_instr, gen_fixed_bl};

    // R4
    load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_mode_load |=> !gen_mode_load);

    // R4
    cfg_held_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_mode_load) |-> $stable(cfg_bus));

    // R4
    cfg_held_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_mode_load |=> $stable(cfg_bus));

    // R2
    fill_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_mode_load && !init_done && gen_addr_mode == ADDR_MODE_SEQ) |->
        (gen_instr_mode == INSTR_MODE_FIXED && gen_fixed_instr == INSTR_CODE_WR &&
         gen_bl_mode == BL_MODE_FIXED));

    // R7
    traffic_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |->
        (gen_addr_mode == ADDR_MODE_PRBS && gen_instr_mode == INSTR_MODE_PRBS &&
         gen_bl_mode == BL_MODE_PRBS));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R8
    done_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(gen_mode_load));

    // R3
    bounds_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> ($stable(gen_start_addr) && $stable(gen_end_addr)));

endmodule

bind meminit_seq meminit_seq_chk #(.AW(AW)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .gen_data_mode   (gen_data_mode),
    .gen_addr_mode   (gen_addr_mode),
    .gen_instr_mode  (gen_instr_mode),
    .gen_bl_mode     (gen_bl_mode),
    .gen_fixed_instr (gen_fixed_instr),
    .gen_fixed_bl    (gen_fixed_bl),
    .gen_start_addr  (gen_start_addr),
    .gen_end_addr    (gen_end_addr),
    .gen_mode_load   (gen_mode_load),
    .init_done       (init_done)
);

// File: tb/meminit_seq_tb.sv
module meminit_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_start_addr = '0;
    logic [AW-1:0] cfg_end_addr = '0;
    logic [3:0]    cfg_pattern = '0;
    logic          cfg_long_burst = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready = 1'b0;
    logic          cmd_is_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [5:0]    cmd_len = '0;
    logic [3:0]    gen_data_mode;
    logic [1:0]    gen_addr_mode;
    logic [3:0]    gen_instr_mode;
    logic [1:0]    gen_bl_mode;
    logic [2:0]    gen_fixed_instr;
    logic [5:0]    gen_fixed_bl;
    logic [AW-1:0] gen_start_addr;
    logic [AW-1:0] gen_end_addr;
    logic          gen_mode_load;
    logic          init_done;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    meminit_seq #(.AW(AW)) dut_i (.*);

    // Behavioural reference: a phase counter and expected output values.
    int         m_phase = 0;
    int         m_dm = 0, m_am = 0, m_im = 0, m_bm = 0, m_fi = 0, m_fb = 0;
    int         m_sa = 0, m_ea = 0, m_ld = 0, m_dn = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0;
            m_dm = 0; m_am = 0; m_im = 0; m_bm = 0; m_fi = 0; m_fb = 0;
            m_sa = 0; m_ea = 0; m_ld = 0; m_dn = 0;
        end else begin
            m_ld = 0;
            case (m_phase)
                0: begin
                    m_sa = int'(cfg_start_addr);
                    m_ea = int'(cfg_end_addr);
                    m_dm = int'(cfg_pattern);
                    m_am = 3; m_im = 1; m_bm = 1; m_fi = 0;
                    m_fb = cfg_long_burst ? 32 : 16;
                    m_phase = 1;
                end
                1: begin m_ld = 1; m_phase = 2; end
                2: m_phase = 3;
                3: if (cmd_valid && cmd_ready && cmd_is_write &&
                       (int'(cmd_addr) + int'(cmd_len) >= m_ea)) begin
                    m_am = 1; m_im = 2; m_bm = 2;
                    m_phase = 4;
                end
                4: begin m_ld = 1; m_phase = 5; end
                5: begin m_dn = 1; m_phase = 6; end
                default: m_phase = 6;
            endcase
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output against the reference on every falling edge.
    always @(negedge clk) begin
        if (!finished) begin
            string cr;
            cr = (!rst_n) ? "R1" : ((m_phase >= 4) ? "R7" : "R2");
            check(cr, "data_mode", int'(gen_data_mode), m_dm);
            check(cr, "addr_mode", int'(gen_addr_mode), m_am);
            check(cr, "instr_mode", int'(gen_instr_mode), m_im);
            check(cr, "bl_mode", int'(gen_bl_mode), m_bm);
            check(cr, "fixed_instr", int'(gen_fixed_instr), m_fi);
            check(cr, "fixed_bl", int'(gen_fixed_bl), m_fb);
            check("R3", "start_addr", int'(gen_start_addr), m_sa);
            check("R3", "end_addr", int'(gen_end_addr), m_ea);
            check("R4", "mode_load", int'(gen_mode_load), m_ld);
            check("R8", "init_done", int'(init_done), m_dn);
        end
    end

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic issue(input logic v, input logic r, input logic w,
                         input int a, input int len);
        cmd_valid = v; cmd_ready = r; cmd_is_write = w;
        cmd_addr = AW'(a); cmd_len = 6'(len);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_ready = 1'b0; cmd_is_write = 1'b0;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        // R1: reset state
        cfg_start_addr = 16'h0100; cfg_end_addr = 16'h0200;
        cfg_pattern = 4'b0010; cfg_long_burst = 1'b0;
        ticks(3);
        check("R1", "load_in_reset", int'(gen_mode_load), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: fill configuration one clock after release
        check("R2", "fill_addr_mode", int'(gen_addr_mode), 3);
        check("R2", "fill_bl16", int'(gen_fixed_bl), 16);
        // R3: later input changes are ignored
        cfg_start_addr = 16'h0AAA; cfg_end_addr = 16'h0123; cfg_pattern = 4'b0111;
        cfg_long_burst = 1'b1;
        @(negedge clk);
        check("R4", "fill_strobe", int'(gen_mode_load), 1);
        // R6: command during the strobe that would reach the end is ignored
        issue(1, 1, 1, 16'h01F0, 16);
        check("R6", "early_cmd", int'(gen_addr_mode), 3);
        for (int a = 'h100; a < 'h1F0; a += 16) issue(1, 1, 1, a, 16);
        check("R6", "below_end", int'(gen_addr_mode), 3);
        issue(1, 1, 0, 16'h01F0, 16);
        check("R6", "read_ignored", int'(gen_addr_mode), 3);
        issue(1, 0, 1, 16'h01F0, 16);
        check("R6", "unready_ignored", int'(gen_addr_mode), 3);
        issue(1, 1, 1, 16'h01EF, 16);
        check("R6", "one_short", int'(gen_addr_mode), 3);
        check("R3", "end_kept", int'(gen_end_addr), 'h200);
        // R5: exact reach completes the fill
        issue(1, 1, 1, 16'h01F0, 16);
        check("R5", "exact_reach", int'(gen_addr_mode), 1);
        check("R7", "data_mode_kept", int'(gen_data_mode), 2);
        @(negedge clk);
        check("R7", "traffic_strobe", int'(gen_mode_load), 1);
        @(negedge clk);
        check("R8", "done_rises", int'(init_done), 1);
        for (int k = 0; k < 6; k++) issue(1, 1, k[0], 16'h0000, 63);
        check("R8", "done_holds", int'(init_done), 1);
        // R1: reset while running clears done
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "done_cleared", int'(init_done), 0);
        // Overshoot near the top of the address space, long bursts
        cfg_start_addr = 16'hFF00; cfg_end_addr = 16'hFFF0;
        cfg_pattern = 4'b0011; cfg_long_burst = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", "fill_bl32", int'(gen_fixed_bl), 32);
        ticks(2);
        issue(1, 1, 1, 16'hFF00, 32);
        check("R6", "far_below", int'(gen_addr_mode), 3);
        issue(1, 1, 1, 16'hFFF0, 32);
        check("R5", "wrap_overshoot", int'(gen_addr_mode), 1);
        ticks(2);
        check("R8", "done_second_run", int'(init_done), 1);
        // Reset mid-fill, then restart
        rst_n = 1'b0;
        @(negedge clk);
        cfg_start_addr = 16'h0000; cfg_end_addr = 16'h0040;
        cfg_pattern = 4'b0001; cfg_long_burst = 1'b0;
        rst_n = 1'b1;
        ticks(4);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "midfill_reset", int'(gen_addr_mode), 0);
        rst_n = 1'b1;
        ticks(3);
        issue(1, 1, 1, 16'h0030, 16);
        ticks(3);
        check("R8", "done_third_run", int'(init_done), 1);
        summary();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        summary();
    end

endmodule